// File: doc/BRIEF.md
# Burst Measurement Control Register File

This block is an AXI4-Lite slave that software uses to drive a single-burst bit-error measurement engine. It holds the three values the engine needs for a run: the frame length in bits, the number of leading preamble bits, and the sample index where bit decisions begin. It reports the engine's three result counters and a fixed identification word. A combined control/status word lets software launch a burst, watch the engine's live busy state, and see a sticky completion flag that stays set until software clears it.

The normal sequence runs as follows. Software reads the identification word to confirm the block is present. It programs the three configuration registers, writes the start bit and polls the status word until the burst finishes. It then reads the counters and writes the completion flag to clear it. The write address and write data channels are independent and may arrive in any order. Reads and writes each complete with an OKAY response.

Top module: `burst_ctl_regs`

## Requirements
- R1: A read of byte offset 0x1C always returns 0x4250534B. After reset the configuration registers at 0x04, 0x08 and 0x0C read zero, and the status word at 0x00 reads zero while the engine is idle.
- R2: A write to offset 0x00 with byte strobe 0 set and data bit 0 equal to 1 drives `eng_start` high for exactly one clock cycle. This happens only if `eng_busy` is low when the write takes effect; a start written while busy produces no pulse. Bit 0 of the status word always reads 0.
- R3: Bit 1 of the word at offset 0x00 reads back the level of `eng_busy` at the cycle the read address is accepted.
- R4: Bit 2 of the word at offset 0x00 is a sticky done flag. A one-cycle `eng_done` pulse sets it, and it stays set across reads. A write to 0x00 with byte strobe 0 set and data bit 2 equal to 1 clears it; with strobe 0 clear the write leaves it unchanged. If a completion and a clear land in the same cycle, the flag ends up set.
- R5: The offsets 0x04 (frame bits), 0x08 (preamble bits) and 0x0C (decision start index) read back what was written and drive `cfg_frame_bits`, `cfg_preamble_bits` and `cfg_start_index`. Each byte lane is updated only when its write strobe bit is 1.
- R6: Offsets 0x10, 0x14 and 0x18 read the current values of `eng_rx_bits`, `eng_total_err` and `eng_payload_err`. Writes to these offsets and to 0x1C change nothing.
- R7: Any offset that is not one of the eight word-aligned addresses 0x00 to 0x1C reads zero, including 0x20 to 0x3C and offsets whose low two bits are nonzero. Writes there change nothing. Every write response and read response is OKAY (2'b00).
- R8: The write address and write data may be accepted in the same cycle or either one before the other. Exactly one write response is issued per write, after both have been accepted.
- R9: Once `s_rvalid` is high it stays high with unchanged `s_rdata` until `s_rready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| eng_busy | input | 1 | Engine busy level |
| eng_done | input | 1 | Engine completion pulse |
| eng_rx_bits | input | DATA_W | Recovered bit count |
| eng_total_err | input | DATA_W | Total bit errors |
| eng_payload_err | input | DATA_W | Payload-only bit errors |
| eng_start | output | 1 | One-cycle burst launch pulse |
| cfg_frame_bits | output | DATA_W | Frame length in bits |
| cfg_preamble_bits | output | DATA_W | Preamble length in bits |
| cfg_start_index | output | DATA_W | Decision start sample index |

## Verification
Configuration writes use random data and random byte-strobe masks. The address and data phases arrive together, address first, or data first, at random gaps. Together these separate a lane-enable fault from a channel-ordering fault. Result counter reads use random engine values, which expose any swapped read-mux leg. Directed cases cover start while idle against start while busy, and the done flag set, held, cleared, and cleared with strobe 0 low. They also cover a completion landing on the clear cycle, which shows whether the set takes priority. Further directed cases read unmapped and unaligned offsets and stall the read with rready low.

// File: rtl/burst_ctl_pkg.sv
package burst_ctl_pkg;
  localparam int IX_W = 3;
  localparam logic [IX_W-1:0] IX_CTRL  = 3'd0;
  localparam logic [IX_W-1:0] IX_FRAME = 3'd1;
  localparam logic [IX_W-1:0] IX_PREAM = 3'd2;
  localparam logic [IX_W-1:0] IX_START = 3'd3;
  localparam logic [IX_W-1:0] IX_RXB   = 3'd4;
  localparam logic [IX_W-1:0] IX_TOT   = 3'd5;
  localparam logic [IX_W-1:0] IX_PAY   = 3'd6;
  localparam logic [IX_W-1:0] IX_IDW   = 3'd7;
  localparam int CTL_GO   = 0;
  localparam int CTL_BUSY = 1;
  localparam int CTL_DONE = 2;
  localparam logic [1:0] RESP_OKAY = 2'b00;
  localparam int NUM_CFG = 3;
endpackage

// File: rtl/bcr_wr_chan.sv
module bcr_wr_chan #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     awaddr,
  input  logic                  awvalid,
  output logic                  awready,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [DATA_W/8-1:0]   wstrb,
  input  logic                  wvalid,
  output logic                  wready,
  output logic [1:0]            bresp,
  output logic                  bvalid,
  input  logic                  bready,
  output logic                  commit,
  output logic [ADDR_W-1:0]     commit_addr,
  output logic [DATA_W-1:0]     commit_data,
  output logic [DATA_W/8-1:0]   commit_strb
);
  import burst_ctl_pkg::*;
  localparam int STRB_W = DATA_W / 8;

  logic              aw_have, w_have, bvalid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [STRB_W-1:0] strb_q;

  assign awready = !aw_have && !bvalid_q;
  assign wready  = !w_have && !bvalid_q;
  assign commit  = aw_have && w_have;
  assign commit_addr = addr_q;
  assign commit_data = data_q;
  assign commit_strb = strb_q;
  assign bvalid = bvalid_q;
  assign bresp  = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_have  <= 1'b0;
      w_have   <= 1'b0;
      bvalid_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      strb_q   <= '0;
    end else begin
      if (awvalid && awready) begin
        aw_have <= 1'b1;
        addr_q  <= awaddr;
      end
      if (wvalid && wready) begin
        w_have <= 1'b1;
        data_q <= wdata;
        strb_q <= wstrb;
      end
      if (commit) begin
        aw_have  <= 1'b0;
        w_have   <= 1'b0;
        bvalid_q <= 1'b1;
      end else if (bvalid_q && bready) begin
        bvalid_q <= 1'b0;
      end
    end
  end

  // R8: a pending response is not withdrawn before it is taken
  a_r8_bvalid_hold: assert property (@(posedge clk) disable iff (rst)
    bvalid && !bready |=> bvalid);
  // R8: no new address or data is taken while a response waits
  a_r8_no_accept_in_resp: assert property (@(posedge clk) disable iff (rst)
    bvalid |-> !awready && !wready);
endmodule

// File: rtl/bcr_rd_chan.sv
module bcr_rd_chan #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic [ADDR_W-1:0] look_addr,
  input  logic [DATA_W-1:0] look_word
);
  import burst_ctl_pkg::*;

  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  assign arready   = !rvalid_q;
  assign look_addr = araddr;
  assign rvalid    = rvalid_q;
  assign rdata     = rdata_q;
  assign rresp     = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (arvalid && arready) begin
      rvalid_q <= 1'b1;
      rdata_q  <= look_word;
    end else if (rvalid_q && rready) begin
      rvalid_q <= 1'b0;
    end
  end

  // R9: read data is held steady while the master stalls
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    rvalid && !rready |=> rvalid && $stable(rdata));
endmodule

// File: rtl/bcr_regbank.sv
module bcr_regbank #(
  parameter int          ADDR_W  = 6,
  parameter int          DATA_W  = 32,
  parameter logic [31:0] ID_WORD = 32'h4250_534B
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [DATA_W/8-1:0] wr_strb,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_word,
  input  logic                eng_busy,
  input  logic                eng_done,
  input  logic [DATA_W-1:0]   eng_rx_bits,
  input  logic [DATA_W-1:0]   eng_total_err,
  input  logic [DATA_W-1:0]   eng_payload_err,
  output logic                eng_start,
  output logic [DATA_W-1:0]   cfg_frame_bits,
  output logic [DATA_W-1:0]   cfg_preamble_bits,
  output logic [DATA_W-1:0]   cfg_start_index
);
  import burst_ctl_pkg::*;
  localparam int STRB_W = DATA_W / 8;
  localparam int HI_LSB = IX_W + 2;

  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    return (a[1:0] == 2'b00) && (a[ADDR_W-1:HI_LSB] == '0);
  endfunction

  logic [IX_W-1:0]   wr_ix, rd_ix;
  logic              wr_ok, ctrl_wr;
  logic              start_q, done_q;
  logic [DATA_W-1:0] cfg_q [NUM_CFG];

  assign wr_ix   = wr_addr[HI_LSB-1:2];
  assign rd_ix   = rd_addr[HI_LSB-1:2];
  assign wr_ok   = wr_en && is_mapped(wr_addr);
  assign ctrl_wr = wr_ok && (wr_ix == IX_CTRL) && wr_strb[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      start_q <= ctrl_wr && wr_data[CTL_GO] && !eng_busy;
      if (eng_done)
        done_q <= 1'b1;
      else if (ctrl_wr && wr_data[CTL_DONE])
        done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CFG; i++) cfg_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CFG; i++)
        for (int b = 0; b < STRB_W; b++)
          if (wr_ok && wr_ix == IX_W'(i + 1) && wr_strb[b])
            cfg_q[i][b*8 +: 8] <= wr_data[b*8 +: 8];
    end
  end

  assign eng_start         = start_q;
  assign cfg_frame_bits    = cfg_q[0];
  assign cfg_preamble_bits = cfg_q[1];
  assign cfg_start_index   = cfg_q[2];

  always_comb begin
    rd_word = '0;
    if (is_mapped(rd_addr)) begin
      case (rd_ix)
        IX_CTRL: begin
          rd_word[CTL_BUSY] = eng_busy;
          rd_word[CTL_DONE] = done_q;
        end
        IX_FRAME: rd_word = cfg_q[0];
        IX_PREAM: rd_word = cfg_q[1];
        IX_START: rd_word = cfg_q[2];
        IX_RXB:   rd_word = eng_rx_bits;
        IX_TOT:   rd_word = eng_total_err;
        IX_PAY:   rd_word = eng_payload_err;
        default:  rd_word = DATA_W'(ID_WORD);
      endcase
    end
  end

  // R2: the launch pulse lasts a single cycle
  a_r2_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);
  // R2: no launch is issued while the engine was busy
  a_r2_no_start_when_busy: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> !$past(eng_busy));
  // R4: a completion always leaves the done flag set
  a_r4_done_sets: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> done_q);
  // R4: the done flag only falls after a control write
  a_r4_done_clear_by_write: assert property (@(posedge clk) disable iff (rst)
    $fell(done_q) |-> $past(ctrl_wr));
endmodule

// File: rtl/burst_ctl_regs.sv
module burst_ctl_regs #(
  parameter int          ADDR_W  = 6,
  parameter int          DATA_W  = 32,
  parameter logic [31:0] ID_WORD = 32'h4250_534B
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [1:0]          s_bresp,
  output logic                s_bvalid,
  input  logic                s_bready,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic                s_arvalid,
  output logic                s_arready,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rvalid,
  input  logic                s_rready,
  input  logic                eng_busy,
  input  logic                eng_done,
  input  logic [DATA_W-1:0]   eng_rx_bits,
  input  logic [DATA_W-1:0]   eng_total_err,
  input  logic [DATA_W-1:0]   eng_payload_err,
  output logic                eng_start,
  output logic [DATA_W-1:0]   cfg_frame_bits,
  output logic [DATA_W-1:0]   cfg_preamble_bits,
  output logic [DATA_W-1:0]   cfg_start_index
);
  localparam int STRB_W = DATA_W / 8;

  logic              commit;
  logic [ADDR_W-1:0] commit_addr, look_addr;
  logic [DATA_W-1:0] commit_data, look_word;
  logic [STRB_W-1:0] commit_strb;

  bcr_wr_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst(rst),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .commit(commit), .commit_addr(commit_addr),
    .commit_data(commit_data), .commit_strb(commit_strb)
  );

  bcr_rd_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .look_addr(look_addr), .look_word(look_word)
  );

  bcr_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_WORD(ID_WORD)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(commit), .wr_addr(commit_addr), .wr_data(commit_data),
    .wr_strb(commit_strb),
    .rd_addr(look_addr), .rd_word(look_word),
    .eng_busy(eng_busy), .eng_done(eng_done),
    .eng_rx_bits(eng_rx_bits), .eng_total_err(eng_total_err),
    .eng_payload_err(eng_payload_err),
    .eng_start(eng_start),
    .cfg_frame_bits(cfg_frame_bits), .cfg_preamble_bits(cfg_preamble_bits),
    .cfg_start_index(cfg_start_index)
  );

  // R7: both channels always answer OKAY
  a_r7_okay_resp: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid |-> s_bresp == 2'b00) and (s_rvalid |-> s_rresp == 2'b00));
endmodule

// File: tb/burst_ctl_regs_tb.sv
module burst_ctl_regs_tb;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, arvalid = 0, bready = 1, rready = 1;
  logic [DW-1:0] wdata = '0;
  logic [3:0] wstrb = '0;
  logic awready, wready, bvalid, arready, rvalid, eng_start;
  logic [1:0] bresp, rresp;
  logic [DW-1:0] rdata, cfg_f, cfg_p, cfg_s;
  logic eng_busy = 0, eng_done = 0;
  logic [DW-1:0] rxb = '0, tot = '0, pay = '0;

  burst_ctl_regs #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .eng_busy(eng_busy), .eng_done(eng_done),
    .eng_rx_bits(rxb), .eng_total_err(tot), .eng_payload_err(pay),
    .eng_start(eng_start),
    .cfg_frame_bits(cfg_f), .cfg_preamble_bits(cfg_p), .cfg_start_index(cfg_s)
  );

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] model [3];

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] d,
                                          input logic [3:0] s);
    logic [DW-1:0] r = old;
    for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] s,
                          input int aw_dly, input int w_dly, input bit pulse_done,
                          output int nb, output int ns);
    nb = 0; ns = 0;
    @(negedge clk);
    fork
      begin
        repeat (aw_dly) @(negedge clk);
        awaddr = a; awvalid = 1;
        while (!awready) @(negedge clk);
        @(posedge clk); @(negedge clk);
        awvalid = 0;
      end
      begin
        repeat (w_dly) @(negedge clk);
        wdata = d; wstrb = s; wvalid = 1;
        while (!wready) @(negedge clk);
        @(posedge clk); @(negedge clk);
        wvalid = 0;
      end
    join
    if (pulse_done) eng_done = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (i == 0) eng_done = 0;
      if (bvalid) begin
        nb++;
        if (bresp !== 2'b00) check("R7 bresp", {30'b0, bresp}, 0);
      end
      if (eng_start) ns++;
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1;
    while (!arready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    arvalid = 0;
    d = rdata;
    if (!rvalid) check("R9 rvalid after accept", 0, 1);
    if (rresp !== 2'b00) check("R7 rresp", {30'b0, rresp}, 0);
    if (rready) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] s);
    int nb, ns;
    do_write(a, d, s, 0, 0, 0, nb, ns);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    int nb, ns;
    void'($urandom(32'd1234));
    for (int i = 0; i < 3; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: reset state and identification word
    check("R1 start idle", {31'b0, eng_start}, 0);
    check("R1 bvalid idle", {31'b0, bvalid}, 0);
    do_read(6'h1C, rd); check("R1 id", rd, 32'h4250534B);
    do_read(6'h00, rd); check("R1 ctrl reset", rd, 0);
    do_read(6'h04, rd); check("R1 frame reset", rd, 0);
    do_read(6'h0C, rd); check("R1 start index reset", rd, 0);

    // R5 and R8: random configuration writes, random strobes, random order
    for (int n = 0; n < 40; n++) begin
      int ix = 1 + ($urandom % 3);
      logic [DW-1:0] d = $urandom;
      logic [3:0] s = 4'($urandom);
      int mode = $urandom % 3;
      int gap = 1 + ($urandom % 3);
      do_write(AW'(ix * 4), d, s, (mode == 2) ? gap : 0, (mode == 1) ? gap : 0, 0, nb, ns);
      model[ix-1] = merge(model[ix-1], d, s);
      check("R8 one response", nb, 1);
      do_read(AW'(ix * 4), rd);
      check("R5 readback", rd, model[ix-1]);
    end
    check("R5 cfg_frame_bits", cfg_f, model[0]);
    check("R5 cfg_preamble_bits", cfg_p, model[1]);
    check("R5 cfg_start_index", cfg_s, model[2]);

    // R6: counters follow the engine inputs
    for (int n = 0; n < 10; n++) begin
      rxb = $urandom; tot = $urandom; pay = $urandom;
      do_read(6'h10, rd); check("R6 rx bits", rd, rxb);
      do_read(6'h14, rd); check("R6 total err", rd, tot);
      do_read(6'h18, rd); check("R6 payload err", rd, pay);
    end
    wr(6'h14, 32'hDEAD_BEEF, 4'hF);
    do_read(6'h14, rd); check("R6 write ignored", rd, tot);
    wr(6'h1C, 32'h0, 4'hF);
    do_read(6'h1C, rd); check("R6 id write ignored", rd, 32'h4250534B);

    // R7: unmapped and unaligned offsets
    wr(6'h24, 32'hFFFF_FFFF, 4'hF);
    do_read(6'h24, rd); check("R7 unmapped read", rd, 0);
    do_read(6'h3C, rd); check("R7 top unmapped read", rd, 0);
    do_read(6'h1D, rd); check("R7 unaligned read", rd, 0);
    wr(6'h05, 32'hFFFF_FFFF, 4'hF);
    do_read(6'h04, rd); check("R7 unaligned write ignored", rd, model[0]);
    wr(6'h20, 32'h1, 4'hF);
    check("R7 frame untouched", cfg_f, model[0]);

    // R2: start pulse
    do_write(6'h00, 32'h1, 4'h1, 0, 0, 0, nb, ns);
    check("R2 one start pulse", ns, 1);
    do_write(6'h00, 32'h1, 4'h2, 0, 0, 0, nb, ns);
    check("R2 start needs strobe 0", ns, 0);
    eng_busy = 1;
    do_write(6'h00, 32'h1, 4'h1, 0, 0, 0, nb, ns);
    check("R2 start ignored while busy", ns, 0);

    // R3: live busy bit
    do_read(6'h00, rd); check("R3 busy high", rd, 32'h2);
    eng_busy = 0;
    do_read(6'h00, rd); check("R3 busy low", rd, 32'h0);

    // R4: sticky done
    @(negedge clk); eng_done = 1; @(negedge clk); eng_done = 0;
    do_read(6'h00, rd); check("R4 done set", rd, 32'h4);
    do_read(6'h00, rd); check("R4 done sticky", rd, 32'h4);
    wr(6'h00, 32'h4, 4'h2);
    do_read(6'h00, rd); check("R4 clear needs strobe 0", rd, 32'h4);
    wr(6'h00, 32'h4, 4'h1);
    do_read(6'h00, rd); check("R4 cleared", rd, 32'h0);
    @(negedge clk); eng_done = 1; @(negedge clk); eng_done = 0;
    do_write(6'h00, 32'h4, 4'h1, 0, 0, 1, nb, ns);
    do_read(6'h00, rd); check("R4 set wins over clear", rd, 32'h4);

    // R9: stalled read holds data
    rready = 0;
    do_read(6'h1C, rd);
    @(negedge clk);
    check("R9 rvalid held", {31'b0, rvalid}, 1);
    check("R9 rdata held", rdata, 32'h4250534B);
    @(negedge clk);
    check("R9 rvalid still held", {31'b0, rvalid}, 1);
    rready = 1;
    @(negedge clk);
    check("R9 rvalid drops", {31'b0, rvalid}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule